// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Shifter

This block sits inside a two-wire serial memory slave and answers a reset pulse with a fixed 32-bit identification word. The word goes out on the shared open-drain data line, one bit per serial clock. The host holds the device selected (chip select low) and pulses the reset input. When that pulse ends, the block takes control of the data line and puts bit 0 of the word on it. After each falling edge of the serial clock it presents the next bit, least significant bit first.

The word is a build-time parameter and cannot be changed at run time. The response does not start in three cases: the device is deselected, the internal nonvolatile write engine reports busy, or the reset input is only held high and has not yet been released.

Deselecting the device at any point ends the response at once. The block then goes back to standby until a new reset pulse arrives.

All pin inputs are sampled through synchroniser flops on the block clock. As a result, every reaction at the outputs follows the pin edge that caused it by a few clock cycles.

Top module: `atr_responder`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `sda_oe_o` is 0 and `sda_o` is 1 (line released, reads high).
- R2: When `atr_rst_i` falls while `cs_ni` is low and `wr_busy_i` is low, `sda_oe_o` becomes 1 within 4 clock cycles, and `sda_o` shows bit 0 of the parameter `ATR_WORD`.
- R3: During a response, the n-th falling edge of `scl_i` (n = 1..31) puts bit n of `ATR_WORD` on `sda_o` within 4 clock cycles, so the word goes out least significant bit first. A rising edge of `scl_i` leaves `sda_o` unchanged.
- R4: The 32nd falling edge of `scl_i` ends the response: `sda_oe_o` returns to 0 and `sda_o` to 1. Further serial clocks do not re-enable the output.
- R5: A reset pulse that ends while `wr_busy_i` is 1 produces no response; `sda_oe_o` stays 0.
- R6: If `cs_ni` goes high during a response, `sda_oe_o` drops to 0 within 4 clock cycles. The response does not resume when `cs_ni` returns low, and serial clocks alone do not restart it.
- R7: A reset pulse that ends while `cs_ni` is high produces no response, even if `cs_ni` goes low afterwards.
- R8: Only the falling edge of `atr_rst_i` starts a response, so a reset level held high has no effect until it is released. Reset pulses during a response are ignored: the bit on the line and the bit count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, samples all pin inputs |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| cs_ni | input | 1 | Chip select pin, active low |
| atr_rst_i | input | 1 | Reset pin; the end of a high pulse requests the identification word |
| scl_i | input | 1 | Serial clock pin |
| wr_busy_i | input | 1 | High while the nonvolatile write engine is running (synchronous to clk_i) |
| sda_o | output | 1 | Data bit for the three-state data line, 1 when released |
| sda_oe_o | output | 1 | Output enable for the data line driver |

## Verification
A corrupted bit counter would show up as a premature or late release of `sda_oe_o` relative to the 32nd serial clock falling edge. A misaligned shift register would show up as a wrong `sda_o` value sampled a few cycles after some falling edge. A standby state that fails to latch would show up as the line being driven after deselection, or after a busy or deselected reset pulse.

The response is checked bit by bit against the parameter word. It is aborted at every one of the 32 bit positions, so each counter value is seen both to advance and to be cleared by deselection. Each fault becomes visible at the ports within four clock cycles of the pin edge that exposes it.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } atr_state_e;
endpackage

// File: rtl/atr_sync.sv
// Multi-bit synchroniser chain; STAGES must be at least 2.
module atr_sync #(
  parameter int unsigned N       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/atr_seq.sv
module atr_seq
  import atr_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_s_i,
  input  logic scl_s_i,
  input  logic cs_n_s_i,
  input  logic busy_i,
  output logic load_o,
  output logic shift_o,
  output logic active_o
);
  localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  atr_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic rst_d_q, scl_d_q;
  logic rst_fall, scl_fall, start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_d_q <= 1'b0;
      scl_d_q <= 1'b0;
    end else begin
      rst_d_q <= rst_pin_s_i;
      scl_d_q <= scl_s_i;
    end
  end

  assign rst_fall = rst_d_q & ~rst_pin_s_i;
  assign scl_fall = scl_d_q & ~scl_s_i;
  assign start    = (state_q == ST_IDLE) && rst_fall && !cs_n_s_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_SEND;
          cnt_q   <= '0;
        end
        ST_SEND: begin
          if (cs_n_s_i) begin
            state_q <= ST_IDLE;
          end else if (scl_fall) begin
            if (cnt_q == LAST) state_q <= ST_IDLE;
            else               cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o   = start;
  assign shift_o  = (state_q == ST_SEND) && !cs_n_s_i && scl_fall;
  assign active_o = (state_q == ST_SEND);

  assert_busy_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && busy_i) |=> !active_o);

  assert_last_bit_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && cnt_q == LAST) |=> !active_o);

  assert_hold_between_clocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !scl_fall && !cs_n_s_i) |=> (active_o && $stable(cnt_q)));
endmodule

// File: rtl/atr_shift.sv
module atr_shift #(
  parameter int unsigned       WIDTH = 32,
  parameter logic [WIDTH-1:0]  WORD  = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic shift_i,
  output logic bit_o
);
  logic [WIDTH-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= WORD;
    else if (shift_i) sreg_q <= {1'b0, sreg_q[WIDTH-1:1]};
  end

  assign bit_o = sreg_q[0];
endmodule

// File: rtl/atr_responder.sv
module atr_responder #(
  parameter int unsigned      WIDTH       = 32,
  parameter logic [WIDTH-1:0] ATR_WORD    = 32'h3B9A_0D51,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic atr_rst_i,
  input  logic scl_i,
  input  logic wr_busy_i,
  output logic sda_o,
  output logic sda_oe_o
);
  logic [2:0] pins_s;
  logic cs_n_s, rst_pin_s, scl_s;
  logic load, shift, active, tx_bit;

  // cs resets deselected; reset pin and scl reset low
  atr_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, atr_rst_i, scl_i}),
    .q_o    (pins_s)
  );
  assign {cs_n_s, rst_pin_s, scl_s} = pins_s;

  atr_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_pin_s_i (rst_pin_s),
    .scl_s_i     (scl_s),
    .cs_n_s_i    (cs_n_s),
    .busy_i      (wr_busy_i),
    .load_o      (load),
    .shift_o     (shift),
    .active_o    (active)
  );

  atr_shift #(.WIDTH(WIDTH), .WORD(ATR_WORD)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .bit_o   (tx_bit)
  );

  assign sda_oe_o = active;
  assign sda_o    = active ? tx_bit : 1'b1;

  assert_deselect_releases_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> !sda_oe_o);

  assert_first_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> (sda_o == ATR_WORD[0]));

  assert_line_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && !shift && !cs_n_s) |=> $stable(sda_o));
endmodule

// File: tb/atr_responder_tb.sv
`timescale 1ns/1ps
module atr_responder_tb;
  localparam logic [31:0] W = 32'hC3A5_96E1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, atr_rst = 1'b0, scl = 1'b0, busy = 1'b0;
  logic sda, sda_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  atr_responder #(.WIDTH(32), .ATR_WORD(W), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .atr_rst_i(atr_rst),
    .scl_i(scl), .wr_busy_i(busy), .sda_o(sda), .sda_oe_o(sda_oe)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
  endtask

  // compares {oe, data} at a negedge
  task automatic chk(input string req, input logic [1:0] exp);
    @(negedge clk);
    n_chk++;
    if ({sda_oe, sda} !== exp) begin
      n_fail++;
      $display("FAIL %s: {oe,sda} got %b expected %b at %0t", req, {sda_oe, sda}, exp, $time);
    end
  endtask

  task automatic rst_pulse();
    atr_rst = 1'b1; step(6); atr_rst = 1'b0; step(6);
  endtask

  task automatic scl_cycle();
    scl = 1'b1; step(6); scl = 1'b0; step(6);
  endtask

  initial begin
    step(3); rst_ni = 1'b1; step(4);
    chk("R1", 2'b01);

    // R7: pulse while deselected
    rst_pulse();
    chk("R7", 2'b01);
    cs_ni = 1'b0; step(6);
    chk("R7", 2'b01);

    // R5: pulse while write busy
    busy = 1'b1; rst_pulse(); chk("R5", 2'b01);
    busy = 1'b0; step(4); chk("R5", 2'b01);

    // R8: held level does nothing until release
    atr_rst = 1'b1; step(20); chk("R8", 2'b01);
    atr_rst = 1'b0; step(6); chk("R2", {1'b1, W[0]});

    // full response
    for (int k = 1; k < 32; k++) begin
      if (k == 10) begin
        rst_pulse();
        chk("R8", {1'b1, W[9]});
      end
      scl = 1'b1; step(6);
      chk("R3", {1'b1, W[k-1]});
      scl = 1'b0; step(6);
      chk("R3", {1'b1, W[k]});
    end
    scl_cycle(); chk("R4", 2'b01);
    scl_cycle(); chk("R4", 2'b01);

    // abort at every bit position
    for (int a = 0; a < 32; a++) begin
      rst_pulse();
      chk("R2", {1'b1, W[0]});
      for (int j = 0; j < a; j++) scl_cycle();
      chk("R3", {1'b1, W[a]});
      cs_ni = 1'b1; step(4);
      chk("R6", 2'b01);
      cs_ni = 1'b0; step(6);
      chk("R6", 2'b01);
      scl_cycle();
      chk("R6", 2'b01);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule